// File: doc/BRIEF.md
# Fly-by DMA Channel Sequencer

This block sequences bus transfers for four peripheral channels without ever holding the data itself. Each peripheral raises a request line. The sequencer picks one eligible channel, asks the host processor to give up the bus, and waits for the host to grant it. It then drives a 16-bit address and one pair of strobes: memory write with I/O read, or memory read with I/O write. The peripheral and the memory exchange the byte directly on the shared data bus. Each channel keeps a current address that counts up and a remaining count that counts down. When the count runs out, the sequencer raises an end-of-process pulse.

Each channel has one of four modes. Single-transfer mode gives the bus back after every transfer. Block mode, once started, runs to the end of the count. Demand mode keeps going only while the peripheral holds its request, and it resumes later from where it stopped. Cascade mode only grants the bus to the peripheral, which then drives the bus itself. With automatic reload enabled, a channel that reaches its terminal count returns to its programmed base address and count and stays armed. Without it, the channel masks itself.

Configuration arrives through a simple per-channel load strobe and a whole-vector mask write. A status output reports a terminal-count flag and a pending-request flag for each channel.

Top module: `flyby_dma_seq`

## Requirements
- R1: A channel is eligible when its request is high and its mask bit is 0. Among eligible channels, channel 0 has the highest priority and channel 3 the lowest. At most one acknowledge is low at a time. While all channels are masked, requests raise no hold request.
- R2: The sequencer raises `hold_req` for an eligible request. It drives no address, strobe or acknowledge until `hold_ack` is high. While `hold_req` is low, every acknowledge stays high.
- R3: A transfer drives one strobe pair. With `prog_to_mem`=1 the pair is `ior_n`/`memw_n`; with 0 it is `memr_n`/`iow_n`. The granted channel's `dack_n` is low during the transfer. The transfer lasts one cycle when `ready` is high. It is extended, with the address held steady, for every cycle that `ready` is low.
- R4: After each transfer the channel address increments by 1 and the count decrements by 1. `eop` is high during the transfer made while the count is 0, and only then.
- R5: A loaded count of N gives N+1 transfers before terminal count.
- R6: Single-transfer mode (`prog_mode`=2'b01) drops `hold_req` after every transfer, so each transfer needs a fresh hold handshake.
- R7: Block mode (`prog_mode`=2'b10) keeps the bus until terminal count, even if the request falls once the acknowledge has gone low.
- R8: Demand mode (`prog_mode`=2'b00) samples the request when each transfer completes. If the request is low, it releases the bus. A later request resumes at the next address, with the count kept.
- R9: Cascade mode (`prog_mode`=2'b11) drives only the channel's `dack_n` low. It keeps `bus_oe` low and all strobes high, and holds the bus until that channel's request falls.
- R10: With `prog_autoinit`=1, terminal count reloads the base address and count, and the channel stays unmasked.
- R11: With `prog_autoinit`=0, terminal count sets the channel's mask bit, so further requests on that channel are ignored.
- R12: `bus_oe` is low for at least one cycle before `hold_req` falls.
- R13: `tc_flags[i]` is set at channel i's terminal count and cleared when channel i is loaded. `req_pend[i]` equals `dreq[i]` AND NOT mask bit i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dreq | input | 4 | Per-channel transfer request |
| dack_n | output | 4 | Per-channel active-low acknowledge |
| hold_req | output | 1 | Bus request to the host |
| hold_ack | input | 1 | Bus grant from the host |
| ready | input | 1 | Low extends the current transfer |
| addr | output | 16 | Transfer address; 0 while `bus_oe` is low |
| bus_oe | output | 1 | Address and strobe drive enable; low models high impedance |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| eop | output | 1 | End-of-process pulse during the terminal-count transfer |
| prog_we | input | 1 | Load configuration into channel `prog_ch` |
| prog_ch | input | 2 | Channel selected for loading |
| prog_addr | input | 16 | Base and current address to load |
| prog_cnt | input | 16 | Base and current count to load (transfers minus one) |
| prog_mode | input | 2 | 00 demand, 01 single, 10 block, 11 cascade |
| prog_autoinit | input | 1 | 1 reloads at terminal count |
| prog_to_mem | input | 1 | 1 selects I/O-to-memory, 0 selects memory-to-I/O |
| mask_we | input | 1 | Write the whole mask vector |
| mask_in | input | 4 | New mask; bit i = 1 masks channel i (all set at reset) |
| tc_flags | output | 4 | Per-channel terminal-count flags |
| req_pend | output | 4 | Per-channel eligible-request flags |

## Verification
The hardest case to reach from the ports is a demand-mode suspension at an exact transfer. The request has to fall after the sequencer has started a given transfer but before the clock edge that completes it. Back-to-back transfers leave only half a cycle for this. The bench keeps a bus monitor that logs each completed transfer at the falling clock edge. It drops the request just after the log reaches the target count, and then checks that the resumed run starts at the next address. A `ready` stall is set up in a similar way: `ready` is held low before the request and released a counted number of cycles after the acknowledge is seen. The bench then checks both the wait-cycle count and that the first logged address is unchanged.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_HOLD = 3'd1,
    SQ_XFER = 3'd2,
    SQ_CASC = 3'd3,
    SQ_DROP = 3'd4
  } seq_state_e;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  logic [1:0]    ld_mode,
  input  logic          ld_auto,
  input  logic          ld_to_mem,
  input  logic          msk_we,
  input  logic          msk_val,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [1:0]    mode,
  output logic          to_mem,
  output logic          masked,
  output logic          tc_flag,
  output logic          at_last
);
  logic [AW-1:0] base_addr_q, base_addr_nx, cur_addr_q, cur_addr_nx;
  logic [CW-1:0] base_cnt_q, base_cnt_nx, cur_cnt_q, cur_cnt_nx;
  logic [1:0]    mode_q, mode_nx;
  logic          auto_q, auto_nx, dir_q, dir_nx, mask_q, mask_nx, tc_q, tc_nx;
  logic          upd;

  assign upd = ld | msk_we | step;

  always_comb begin
    base_addr_nx = base_addr_q;
    base_cnt_nx  = base_cnt_q;
    cur_addr_nx  = cur_addr_q;
    cur_cnt_nx   = cur_cnt_q;
    mode_nx      = mode_q;
    auto_nx      = auto_q;
    dir_nx       = dir_q;
    mask_nx      = mask_q;
    tc_nx        = tc_q;
    if (ld) begin
      base_addr_nx = ld_addr;
      base_cnt_nx  = ld_cnt;
      cur_addr_nx  = ld_addr;
      cur_cnt_nx   = ld_cnt;
      mode_nx      = ld_mode;
      auto_nx      = ld_auto;
      dir_nx       = ld_to_mem;
      tc_nx        = 1'b0;
    end
    if (msk_we) mask_nx = msk_val;
    if (step) begin
      if (cur_cnt_q == '0) begin
        tc_nx = 1'b1;
        if (auto_q) begin
          cur_addr_nx = base_addr_q;
          cur_cnt_nx  = base_cnt_q;
        end else begin
          cur_addr_nx = cur_addr_q + 1'b1;
          cur_cnt_nx  = cur_cnt_q - 1'b1;
          mask_nx     = 1'b1;
        end
      end else begin
        cur_addr_nx = cur_addr_q + 1'b1;
        cur_cnt_nx  = cur_cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= 2'b01;
      auto_q      <= 1'b0;
      dir_q       <= 1'b0;
      mask_q      <= 1'b1;
      tc_q        <= 1'b0;
    end else if (upd) begin
      base_addr_q <= base_addr_nx;
      base_cnt_q  <= base_cnt_nx;
      cur_addr_q  <= cur_addr_nx;
      cur_cnt_q   <= cur_cnt_nx;
      mode_q      <= mode_nx;
      auto_q      <= auto_nx;
      dir_q       <= dir_nx;
      mask_q      <= mask_nx;
      tc_q        <= tc_nx;
    end
  end

  assign cur_addr = cur_addr_q;
  assign mode     = mode_q;
  assign to_mem   = dir_q;
  assign masked   = mask_q;
  assign tc_flag  = tc_q;
  assign at_last  = (cur_cnt_q == '0);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic blocked;

  always_comb begin
    blocked = 1'b0;
    grant   = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] & ~blocked;
      blocked  = blocked | req[i];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/dma_bus_fsm.sv
module dma_bus_fsm
  import flyby_dma_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_any,
  input  logic [IW-1:0] win_idx,
  input  logic          win_cascade,
  input  logic          hold_ack,
  input  logic          ready,
  input  logic [1:0]    act_mode,
  input  logic          act_to_mem,
  input  logic          act_last,
  input  logic          act_dreq,
  output logic [IW-1:0] act_ch,
  output logic          hold_req,
  output logic          bus_oe,
  output logic [N-1:0]  dack_n,
  output logic [N-1:0]  step,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n,
  output logic          eop
);
  seq_state_e    st_q, st_nx;
  logic [IW-1:0] ch_q, ch_nx;
  logic          done;
  logic          granting;

  always_comb begin
    st_nx = st_q;
    ch_nx = ch_q;
    done  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (win_any) st_nx = SQ_HOLD;
      SQ_HOLD: begin
        if (!win_any) begin
          st_nx = SQ_IDLE;
        end else if (hold_ack) begin
          ch_nx = win_idx;
          st_nx = win_cascade ? SQ_CASC : SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (ready) begin
          done = 1'b1;
          if (act_last || (act_mode == XM_SINGLE) ||
              ((act_mode == XM_DEMAND) && !act_dreq))
            st_nx = SQ_DROP;
        end
      end
      SQ_CASC: if (!act_dreq) st_nx = SQ_DROP;
      SQ_DROP: st_nx = SQ_IDLE;
      default: st_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      ch_q <= '0;
    end else begin
      st_q <= st_nx;
      ch_q <= ch_nx;
    end
  end

  assign act_ch   = ch_q;
  assign hold_req = (st_q != SQ_IDLE);
  assign bus_oe   = (st_q == SQ_XFER);
  assign granting = (st_q == SQ_XFER) || (st_q == SQ_CASC);
  assign memr_n   = ~(bus_oe & ~act_to_mem);
  assign iow_n    = ~(bus_oe & ~act_to_mem);
  assign ior_n    = ~(bus_oe & act_to_mem);
  assign memw_n   = ~(bus_oe & act_to_mem);
  assign eop      = done & act_last;

  for (genvar gi = 0; gi < N; gi++) begin : g_lane
    assign dack_n[gi] = ~(granting && (ch_q == IW'(gi)));
    assign step[gi]   = done && (ch_q == IW'(gi));
  end
endmodule

// File: rtl/flyby_dma_seq.sv
module flyby_dma_seq
  import flyby_dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack_n,
  output logic           hold_req,
  input  logic           hold_ack,
  input  logic           ready,
  output logic [AW-1:0]  addr,
  output logic           bus_oe,
  output logic           memr_n,
  output logic           memw_n,
  output logic           ior_n,
  output logic           iow_n,
  output logic           eop,
  input  logic           prog_we,
  input  logic [IW-1:0]  prog_ch,
  input  logic [AW-1:0]  prog_addr,
  input  logic [CW-1:0]  prog_cnt,
  input  logic [1:0]     prog_mode,
  input  logic           prog_autoinit,
  input  logic           prog_to_mem,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_in,
  output logic [NCH-1:0] tc_flags,
  output logic [NCH-1:0] req_pend
);
  logic           rst_n_i;
  logic [AW-1:0]  ch_addr [NCH];
  logic [1:0]     ch_mode [NCH];
  logic [NCH-1:0] ch_dir, ch_mask, ch_last, ch_step, eligible, grant;
  logic [IW-1:0]  win_idx, act_ch;
  logic           win_any;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .ld       (prog_we && (prog_ch == IW'(gc))),
      .ld_addr  (prog_addr),
      .ld_cnt   (prog_cnt),
      .ld_mode  (prog_mode),
      .ld_auto  (prog_autoinit),
      .ld_to_mem(prog_to_mem),
      .msk_we   (mask_we),
      .msk_val  (mask_in[gc]),
      .step     (ch_step[gc]),
      .cur_addr (ch_addr[gc]),
      .mode     (ch_mode[gc]),
      .to_mem   (ch_dir[gc]),
      .masked   (ch_mask[gc]),
      .tc_flag  (tc_flags[gc]),
      .at_last  (ch_last[gc])
    );
  end

  assign eligible = dreq & ~ch_mask;
  assign req_pend = eligible;

  dma_prio_pick #(.N(NCH), .IW(IW)) u_pick (
    .req(eligible), .grant(grant), .idx(win_idx), .any(win_any)
  );

  dma_bus_fsm #(.N(NCH), .IW(IW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .win_any    (win_any),
    .win_idx    (win_idx),
    .win_cascade(ch_mode[win_idx] == XM_CASCADE),
    .hold_ack   (hold_ack),
    .ready      (ready),
    .act_mode   (ch_mode[act_ch]),
    .act_to_mem (ch_dir[act_ch]),
    .act_last   (ch_last[act_ch]),
    .act_dreq   (dreq[act_ch]),
    .act_ch     (act_ch),
    .hold_req   (hold_req),
    .bus_oe     (bus_oe),
    .dack_n     (dack_n),
    .step       (ch_step),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .ior_n      (ior_n),
    .iow_n      (iow_n),
    .eop        (eop)
  );

  assign addr = bus_oe ? ch_addr[act_ch] : '0;

  logic unused_grant;
  assign unused_grant = ^grant;
endmodule

// File: rtl/flyby_dma_chk.sv
module flyby_dma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           ready,
  input logic           bus_oe,
  input logic [NCH-1:0] dack_n,
  input logic           memr_n,
  input logic           memw_n,
  input logic           ior_n,
  input logic           iow_n,
  input logic [AW-1:0]  addr,
  input logic           eop
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dack_n)); // R1
  AST_BUS_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe || (dack_n != '1)) |-> hold_ack); // R2
  AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_req |-> (dack_n == '1)); // R2
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ((ior_n == memw_n) && (memr_n == iow_n) && (ior_n != memr_n))); // R3
  AST_WAIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !ready) |=> (bus_oe && $stable(addr))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ready && !eop) |=> (!bus_oe || (addr == AW'($past(addr) + 1'b1)))); // R4
  AST_EOP_CONTEXT: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (bus_oe && ready)); // R4
  AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (memr_n && memw_n && ior_n && iow_n)); // R9
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> !$past(bus_oe)); // R12
endmodule

bind flyby_dma_seq flyby_dma_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_req(hold_req), .hold_ack(hold_ack),
  .ready(ready), .bus_oe(bus_oe), .dack_n(dack_n), .memr_n(memr_n),
  .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .addr(addr), .eop(eop)
);

// File: tb/test_flyby_dma_seq.sv
`timescale 1ns/1ps
module test_flyby_dma_seq;
  localparam logic [1:0] M_DEM = 2'b00, M_SGL = 2'b01, M_BLK = 2'b10, M_CAS = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dreq = '0;
  logic [3:0]  dack_n;
  logic        hold_req, hold_ack, ready = 1'b1;
  logic [15:0] addr;
  logic        bus_oe, memr_n, memw_n, ior_n, iow_n, eop;
  logic        prog_we = 1'b0;
  logic [1:0]  prog_ch = '0;
  logic [15:0] prog_addr = '0, prog_cnt = '0;
  logic [1:0]  prog_mode = '0;
  logic        prog_autoinit = 1'b0, prog_to_mem = 1'b0;
  logic        mask_we = 1'b0;
  logic [3:0]  mask_in = '0;
  logic [3:0]  tc_flags, req_pend;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flyby_dma_seq i_flyby_dma_seq (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack_n(dack_n), .hold_req(hold_req),
    .hold_ack(hold_ack), .ready(ready), .addr(addr), .bus_oe(bus_oe),
    .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n), .eop(eop),
    .prog_we(prog_we), .prog_ch(prog_ch), .prog_addr(prog_addr), .prog_cnt(prog_cnt),
    .prog_mode(prog_mode), .prog_autoinit(prog_autoinit), .prog_to_mem(prog_to_mem),
    .mask_we(mask_we), .mask_in(mask_in), .tc_flags(tc_flags), .req_pend(req_pend)
  );

  // host model: grants the bus one cycle after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req;
  end

  // bus monitor
  logic [15:0] lg_addr [64];
  int          lg_ch   [64];
  bit          lg_eop  [64];
  bit          lg_tomem[64];
  int lg_n = 0, hreq_rises = 0, order_viol = 0, hold_viol = 0, wait_cnt = 0, eop_cnt = 0;
  bit prev_hreq = 0, prev_oe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_req && !prev_hreq) hreq_rises++;
      if (!hold_req && prev_hreq && prev_oe) order_viol++;
      if ((bus_oe || dack_n != 4'hF) && !hold_ack) hold_viol++;
      if (bus_oe && !ready) wait_cnt++;
      if (eop) eop_cnt++;
      if (bus_oe && ready && lg_n < 64) begin
        lg_addr[lg_n]  = addr;
        lg_eop[lg_n]   = eop;
        lg_tomem[lg_n] = (!ior_n && !memw_n);
        lg_ch[lg_n]    = -1;
        for (int i = 0; i < 4; i++) if (!dack_n[i]) lg_ch[lg_n] = i;
        lg_n++;
      end
      prev_hreq = hold_req;
      prev_oe   = bus_oe;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic program_ch(input int ch, input logic [15:0] a, input logic [15:0] c,
                            input logic [1:0] m, input bit ai, input bit tm);
    @(negedge clk); #1;
    prog_we = 1'b1; prog_ch = 2'(ch); prog_addr = a; prog_cnt = c;
    prog_mode = m; prog_autoinit = ai; prog_to_mem = tm;
    @(negedge clk); #1;
    prog_we = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); #1;
    mask_we = 1'b1; mask_in = m;
    @(negedge clk); #1;
    mask_we = 1'b0;
  endtask

  task automatic wait_quiet();
    int quiet = 0;
    for (int k = 0; k < 400 && quiet < 4; k++) begin
      @(negedge clk);
      quiet = hold_req ? 0 : quiet + 1;
    end
  endtask

  task automatic wait_logs(input int n);
    for (int k = 0; k < 400 && lg_n < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    chk("R2", "hold_req after reset", hold_req, 0);
    chk("R2", "bus_oe after reset", bus_oe, 0);
    chk("R2", "dack_n after reset", dack_n, 4'hF);
    chk("R3", "strobes after reset", {memr_n, memw_n, ior_n, iow_n}, 4'hF);
    chk("R13", "status after reset", {tc_flags, req_pend}, 8'h00);
    @(negedge clk); #1; dreq = 4'hF;
    repeat (8) @(negedge clk);
    chk("R1", "masked requests raise no hold", hold_req, 0);
    chk("R13", "masked requests not pending", req_pend, 4'h0);
    dreq = 4'h0;
  endtask

  task automatic t_single();
    int r0 = hreq_rises, e0 = eop_cnt;
    program_ch(2, 16'h3456, 16'd2, M_SGL, 1'b0, 1'b1);
    set_mask(4'b1011);
    lg_n = 0;
    dreq[2] = 1'b1;
    repeat (60) @(negedge clk);
    chk("R5", "count 2 gives 3 transfers", lg_n, 3);
    for (int i = 0; i < 3; i++) begin
      chk("R4", "single address", lg_addr[i], 16'h3456 + i);
      chk("R3", "single channel", lg_ch[i], 2);
      chk("R3", "io-to-mem strobe pair", lg_tomem[i], 1);
    end
    chk("R4", "eop on last only", lg_eop[2], 1);
    chk("R4", "eop count", eop_cnt - e0, 1);
    chk("R6", "one hold per transfer", hreq_rises - r0, 3);
    chk("R13", "tc flag ch2", tc_flags[2], 1);
    chk("R11", "masked after tc, request ignored", req_pend[2], 0);
    dreq[2] = 1'b0;
    wait_quiet();
  endtask

  task automatic t_block();
    int r0 = hreq_rises, w0 = wait_cnt, e0 = eop_cnt;
    program_ch(1, 16'h0100, 16'd4, M_BLK, 1'b0, 1'b0);
    set_mask(4'b1101);
    lg_n = 0;
    @(negedge clk); #1; ready = 1'b0; dreq[1] = 1'b1;
    for (int k = 0; k < 50 && dack_n[1] !== 1'b0; k++) @(negedge clk);
    dreq[1] = 1'b0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1; ready = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7", "block runs to tc after request drop", lg_n, 5);
    for (int i = 0; i < 5; i++) begin
      chk("R4", "block address", lg_addr[i], 16'h0100 + i);
      chk("R3", "mem-to-io strobe pair", lg_tomem[i], 0);
    end
    chk("R3", "ready-low wait cycles", wait_cnt - w0, 4);
    chk("R7", "block holds bus once", hreq_rises - r0, 1);
    chk("R4", "block eop on last", lg_eop[4], 1);
    chk("R4", "block eop count", eop_cnt - e0, 1);
    wait_quiet();
  endtask

  task automatic t_demand();
    int r0 = hreq_rises, e0 = eop_cnt;
    program_ch(3, 16'h0200, 16'd9, M_DEM, 1'b0, 1'b1);
    set_mask(4'b0111);
    lg_n = 0;
    @(negedge clk); #1; dreq[3] = 1'b1;
    wait_logs(3);
    dreq[3] = 1'b0;
    wait_quiet();
    chk("R8", "demand suspends on request drop", lg_n, 3);
    chk("R8", "no eop on suspend", eop_cnt - e0, 0);
    chk("R13", "no tc on suspend", tc_flags[3], 0);
    @(negedge clk); #1; dreq[3] = 1'b1;
    wait_logs(5);
    dreq[3] = 1'b0;
    wait_quiet();
    chk("R8", "demand resumed transfers", lg_n, 5);
    chk("R8", "resume address", lg_addr[3], 16'h0203);
    chk("R8", "resume next address", lg_addr[4], 16'h0204);
    chk("R8", "two hold handshakes", hreq_rises - r0, 2);
  endtask

  task automatic t_cascade();
    program_ch(0, 16'h0000, 16'd0, M_CAS, 1'b0, 1'b0);
    set_mask(4'b1110);
    lg_n = 0;
    @(negedge clk); #1; dreq[0] = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9", "cascade acknowledge only", dack_n, 4'b1110);
    chk("R9", "cascade bus_oe low", bus_oe, 0);
    chk("R9", "cascade strobes idle", {memr_n, memw_n, ior_n, iow_n}, 4'hF);
    chk("R9", "cascade holds bus", hold_req, 1);
    dreq[0] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9", "cascade released acks", dack_n, 4'hF);
    chk("R9", "cascade released hold", hold_req, 0);
    chk("R9", "cascade made no transfer", lg_n, 0);
  endtask

  task automatic t_priority();
    program_ch(1, 16'h1000, 16'd0, M_SGL, 1'b0, 1'b1);
    program_ch(3, 16'h3000, 16'd0, M_SGL, 1'b0, 1'b1);
    set_mask(4'b0101);
    lg_n = 0;
    @(negedge clk); #1; dreq = 4'b1010;
    repeat (40) @(negedge clk);
    chk("R1", "two transfers", lg_n, 2);
    chk("R1", "channel 1 first", lg_ch[0], 1);
    chk("R1", "channel 3 second", lg_ch[1], 3);
    chk("R1", "ch1 address", lg_addr[0], 16'h1000);
    chk("R1", "ch3 address", lg_addr[1], 16'h3000);
    chk("R13", "tc flags", tc_flags, 4'b1110);
    chk("R11", "both masked after tc", req_pend, 4'b0000);
    dreq = 4'b0000;
    wait_quiet();
  endtask

  task automatic t_autoinit();
    int e0;
    program_ch(2, 16'h0500, 16'd1, M_SGL, 1'b1, 1'b1);
    chk("R13", "load clears tc flag", tc_flags[2], 0);
    set_mask(4'b1011);
    lg_n = 0;
    e0 = eop_cnt;
    @(negedge clk); #1; dreq[2] = 1'b1;
    wait_logs(5);
    dreq[2] = 1'b0;
    wait_quiet();
    chk("R10", "autoinit transfer count", lg_n, 5);
    for (int i = 0; i < 5; i++)
      chk("R10", "autoinit address", lg_addr[i], (i % 2 == 0) ? 16'h0500 : 16'h0501);
    chk("R10", "eop each wrap", eop_cnt - e0, 2);
    chk("R10", "eop at index 1", lg_eop[1], 1);
    chk("R13", "tc flag after wrap", tc_flags[2], 1);
    @(negedge clk); #1; dreq[2] = 1'b1;
    #1 chk("R10", "channel stays armed", req_pend[2], 1);
    dreq[2] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_block();
    t_demand();
    t_cascade();
    t_priority();
    t_autoinit();
    chk("R2", "bus never driven without grant", hold_viol, 0);
    chk("R12", "oe low before hold drop", order_viol, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule